// File: doc/BRIEF.md
# Lockable Watchdog Timer with Selectable Timebase

This block is a watchdog counter that raises a system reset request when software stops servicing it. Software talks to it over a small register bus with two word addresses: a configuration register and a service address. The configuration register holds three control bits: enable, timebase source and timeout length. It accepts exactly one write after each reset and then stays frozen, so a runaway program cannot switch the watchdog off or stretch its timeout. A write of any value to the service address restarts the count. The service address stores nothing and always reads as zero.

The count advances on every bus clock or on each rising edge of a slow tick input of about 1 kHz. The slow tick is asynchronous and passes through a synchronizer first. Each source has a short and a long timeout, which gives four timeout lengths. On expiry the block emits a single-cycle reset request and restarts its count. If nothing resets the system, the requests repeat at the same period.

Top module: `guard_wdt`

## Requirements
- R1: After reset the configuration register reads back 3'b111: bit 0 is enable (1 = on), bit 1 is source (1 = bus clock, 0 = slow tick) and bit 2 is length (1 = long). The reset request is low.
- R2: While enabled, a reset request is raised on the 2^N-th count event after the most recent counter clear, where N is the log-length of the selected timeout.
- R3: With the bus-clock source, the short timeout is 2^BUS_SHORT_LOG cycles (default 2^13) and the long timeout is 2^BUS_LONG_LOG cycles (default 2^18).
- R4: With the slow-tick source, the short timeout is 2^SLOW_SHORT_LOG ticks (default 2^5) and the long timeout is 2^SLOW_LONG_LOG ticks (default 2^8). Bus cycles without a tick do not advance the count.
- R5: A write of any data to the service address (word 1) clears the counter. A read of that address returns zero.
- R6: Only the first write to the configuration address (word 0) after reset is accepted. Later writes change neither the register nor the counter until the next reset.
- R7: The accepted configuration write also clears the counter.
- R8: With enable at 0 the counter is held at zero and no reset request is produced.
- R9: The reset request lasts exactly one bus cycle. The counter then restarts from zero, so an unserviced watchdog pulses at the timeout period.
- R10: A service write in the same cycle as the timeout wins: the counter clears and no reset request is issued.
- R11: The slow tick passes through a two-flop synchronizer. Each rising edge gives exactly one count event, however long the level stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slow_tick_i | input | 1 | Asynchronous slow tick level, about 1 kHz |
| bus_addr_i | input | ADDR_W | Word address: 0 configuration, 1 service |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | DATA_W | Write data; configuration uses bits 2:0 |
| bus_rdata_o | output | DATA_W | Combinational read data for bus_addr_i |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The service write and the timeout compare can fall in the same cycle. The bench provokes this by placing a service write exactly on the edge where the count reaches its limit, measured in cycles from the configuration write. It judges the result by two things: no request must appear on that cycle, and the next request must come one full period after the service write. A second coincidence tests the clear from the first configuration write against a count that is already running. A late configuration write placed mid-count must not shift the pulse.

// File: rtl/guard_wdt_pkg.sv
package guard_wdt_pkg;

  // bit 2: long timeout, bit 1: bus clock source, bit 0: enable
  typedef struct packed {
    logic tmo_long;
    logic src_bus;
    logic enable;
  } wdt_cfg_t;

  localparam int unsigned CFG_BITS = 3;
  localparam wdt_cfg_t CFG_RST = '{tmo_long: 1'b1, src_bus: 1'b1, enable: 1'b1};

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/gw_tick_sync.sv
module gw_tick_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= tick_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], tick_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/gw_cfg_regs.sv
module gw_cfg_regs
  import guard_wdt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CFG_ADDR = 0,
  parameter int unsigned SVC_ADDR = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output wdt_cfg_t          cfg_o,
  output logic              locked_o,
  output logic              cfg_first_wr_o,
  output logic              svc_wr_o
);
  localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_ADDR);
  localparam logic [ADDR_W-1:0] SVC_A = ADDR_W'(SVC_ADDR);

  wdt_cfg_t cfg_q;
  logic     locked_q;
  logic     cfg_hit;
  logic     unused_wdata;

  assign cfg_hit        = we_i && (addr_i == CFG_A);
  assign cfg_first_wr_o = cfg_hit && !locked_q;
  assign svc_wr_o       = we_i && (addr_i == SVC_A);
  assign unused_wdata   = ^wdata_i[DATA_W-1:CFG_BITS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= CFG_RST;
      locked_q <= 1'b0;
    end else if (cfg_first_wr_o) begin
      cfg_q    <= wdt_cfg_t'(wdata_i[CFG_BITS-1:0]);
      locked_q <= 1'b1;
    end
  end

  // service address holds nothing and reads zero
  always_comb begin
    rdata_o = '0;
    if (addr_i == CFG_A) rdata_o[CFG_BITS-1:0] = cfg_q;
  end

  assign cfg_o    = cfg_q;
  assign locked_o = locked_q;
endmodule

// File: rtl/gw_counter.sv
module gw_counter
  import guard_wdt_pkg::*;
#(
  parameter int unsigned SLOW_SHORT_LOG = 5,
  parameter int unsigned SLOW_LONG_LOG  = 8,
  parameter int unsigned BUS_SHORT_LOG  = 13,
  parameter int unsigned BUS_LONG_LOG   = 18,
  parameter int unsigned CNT_W          = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  wdt_cfg_t         cfg_i,
  input  logic             slow_rise_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] lim_o,
  output logic             rst_req_o
);
  localparam logic [CNT_W-1:0] LIM_SS = CNT_W'((64'd1 << SLOW_SHORT_LOG) - 64'd1);
  localparam logic [CNT_W-1:0] LIM_SL = CNT_W'((64'd1 << SLOW_LONG_LOG) - 64'd1);
  localparam logic [CNT_W-1:0] LIM_BS = CNT_W'((64'd1 << BUS_SHORT_LOG) - 64'd1);
  localparam logic [CNT_W-1:0] LIM_BL = CNT_W'((64'd1 << BUS_LONG_LOG) - 64'd1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             step;
  logic             expire;
  logic             req_q;

  always_comb begin
    unique case ({cfg_i.src_bus, cfg_i.tmo_long})
      2'b00:   lim = LIM_SS;
      2'b01:   lim = LIM_SL;
      2'b10:   lim = LIM_BS;
      default: lim = LIM_BL;
    endcase
  end

  assign step   = cfg_i.src_bus | slow_rise_i;
  // service or first config write overrides the expiry
  assign expire = cfg_i.enable && step && (cnt_q == lim) && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= expire;
      if (!cfg_i.enable || clr_i || expire) cnt_q <= '0;
      else if (step)                        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o     = cnt_q;
  assign lim_o     = lim;
  assign rst_req_o = req_q;
endmodule

// File: rtl/guard_wdt.sv
module guard_wdt
  import guard_wdt_pkg::*;
#(
  parameter int unsigned ADDR_W         = 4,
  parameter int unsigned DATA_W         = 8,
  parameter int unsigned CFG_ADDR       = 0,
  parameter int unsigned SVC_ADDR       = 1,
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned SLOW_SHORT_LOG = 5,
  parameter int unsigned SLOW_LONG_LOG  = 8,
  parameter int unsigned BUS_SHORT_LOG  = 13,
  parameter int unsigned BUS_LONG_LOG   = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_tick_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              rst_req_o
);
  localparam int unsigned CNT_W =
    max2(max2(SLOW_SHORT_LOG, SLOW_LONG_LOG), max2(BUS_SHORT_LOG, BUS_LONG_LOG));

  wdt_cfg_t         cfg;
  logic             locked;
  logic             cfg_first_wr;
  logic             svc_wr;
  logic             slow_rise;
  logic [CNT_W-1:0] cnt_val;
  logic [CNT_W-1:0] lim_val;

  gw_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (slow_tick_i),
    .rise_o (slow_rise)
  );

  gw_cfg_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CFG_ADDR (CFG_ADDR),
    .SVC_ADDR (SVC_ADDR)
  ) u_regs (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .addr_i         (bus_addr_i),
    .we_i           (bus_we_i),
    .wdata_i        (bus_wdata_i),
    .rdata_o        (bus_rdata_o),
    .cfg_o          (cfg),
    .locked_o       (locked),
    .cfg_first_wr_o (cfg_first_wr),
    .svc_wr_o       (svc_wr)
  );

  gw_counter #(
    .SLOW_SHORT_LOG (SLOW_SHORT_LOG),
    .SLOW_LONG_LOG  (SLOW_LONG_LOG),
    .BUS_SHORT_LOG  (BUS_SHORT_LOG),
    .BUS_LONG_LOG   (BUS_LONG_LOG),
    .CNT_W          (CNT_W)
  ) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_i       (cfg),
    .slow_rise_i (slow_rise),
    .clr_i       (svc_wr | cfg_first_wr),
    .cnt_o       (cnt_val),
    .lim_o       (lim_val),
    .rst_req_o   (rst_req_o)
  );
endmodule

// File: rtl/guard_wdt_sva.sv
module guard_wdt_sva #(
  parameter int unsigned CNT_W = 18
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       cfg,
  input logic             locked,
  input logic             cfg_first_wr,
  input logic             svc_wr,
  input logic [CNT_W-1:0] cnt_val,
  input logic [CNT_W-1:0] lim_val,
  input logic             rst_req_o
);
  p_reset_cfg_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked |-> (cfg == 3'b111));

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_val <= lim_val);

  p_svc_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_wr |=> (cnt_val == '0));

  p_lock_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |=> (locked && $stable(cfg)));

  p_first_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_first_wr |=> (cnt_val == '0));

  p_disabled_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg[0] |=> (cnt_val == '0 && !rst_req_o));

  p_single_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  p_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (cnt_val == '0));

  p_svc_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_wr |=> !rst_req_o);
endmodule

bind guard_wdt guard_wdt_sva #(.CNT_W(CNT_W)) u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg          (cfg),
  .locked       (locked),
  .cfg_first_wr (cfg_first_wr),
  .svc_wr       (svc_wr),
  .cnt_val      (cnt_val),
  .lim_val      (lim_val),
  .rst_req_o    (rst_req_o)
);

// File: tb/guard_wdt_test.sv
module guard_wdt_test;
  localparam int unsigned SS = 3, SL = 4, BS = 5, BL = 7;
  localparam int unsigned LEN_SS = 1 << SS, LEN_SL = 1 << SL;
  localparam int unsigned LEN_BS = 1 << BS, LEN_BL = 1 << BL;

  // {cfg[2:0], expected length; 0 = disabled}
  localparam logic [18:0] VECS [5] = '{
    {3'b111, 16'(LEN_BL)},
    {3'b011, 16'(LEN_BS)},
    {3'b001, 16'(LEN_SS)},
    {3'b101, 16'(LEN_SL)},
    {3'b110, 16'd0}
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       slow_tick_i = 1'b0;
  logic [3:0] bus_addr_i = '0;
  logic       bus_we_i = 1'b0;
  logic [7:0] bus_wdata_i = '0;
  logic [7:0] bus_rdata_o;
  logic       rst_req_o;

  int checks = 0, fails = 0, pulse_cnt = 0, base = 0;
  bit done = 0;

  always #10 clk = ~clk;

  guard_wdt #(
    .SLOW_SHORT_LOG(SS), .SLOW_LONG_LOG(SL),
    .BUS_SHORT_LOG(BS), .BUS_LONG_LOG(BL)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni), .slow_tick_i(slow_tick_i),
    .bus_addr_i(bus_addr_i), .bus_we_i(bus_we_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .rst_req_o(rst_req_o)
  );

  always @(negedge clk) if (rst_ni && rst_req_o === 1'b1) pulse_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; bus_we_i = 1'b0; slow_tick_i = 1'b0;
    step(3);
    rst_ni = 1'b1;
    step(1);
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1;
    step(1);
    bus_we_i = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output int d);
    bus_addr_i = a;
    #1 d = int'(bus_rdata_o);
  endtask

  task automatic tick(input int hi);
    slow_tick_i = 1'b1; step(hi);
    slow_tick_i = 1'b0; step(3);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
    end
  end

  initial begin
    int rd;
    // table walk: one configuration per reset
    for (int i = 0; i < 5; i++) begin
      logic [2:0] c;
      int len;
      c = VECS[i][18:16];
      len = int'(VECS[i][15:0]);
      do_reset();
      bus_write(4'd0, {5'b0, c});
      base = pulse_cnt;
      if (len == 0) begin
        step(3 * LEN_BL);
        chk("R8 disabled pulses", pulse_cnt - base, 0);
      end else if (c[1]) begin
        step(len - 1);
        chk("R3 no early pulse", pulse_cnt - base, 0);
        step(1);
        chk("R2 R3 pulse at timeout", int'(rst_req_o), 1);
        step(1);
        chk("R9 pulse width", int'(rst_req_o), 0);
        step(len - 2);
        chk("R9 quiet between pulses", pulse_cnt - base, 1);
        step(1);
        chk("R9 periodic pulse", int'(rst_req_o), 1);
      end else begin
        for (int t = 0; t < len - 1; t++) tick(3);
        chk("R4 no early pulse", pulse_cnt - base, 0);
        tick(3);
        chk("R4 pulse after ticks", pulse_cnt - base, 1);
      end
    end

    // R1 reset state and default timeout
    do_reset();
    bus_read(4'd0, rd);
    chk("R1 cfg reset value", rd, 7);
    chk("R1 request low", int'(rst_req_o), 0);
    step(1);
    bus_write(4'd1, 8'hA5);
    base = pulse_cnt;
    bus_read(4'd1, rd);
    chk("R5 service reads zero", rd, 0);
    step(LEN_BL - 1);
    chk("R1 default long bus no early pulse", pulse_cnt - base, 0);
    step(1);
    chk("R1 default long bus timeout", int'(rst_req_o), 1);

    // R6 late write ignored, counter untouched
    do_reset();
    bus_write(4'd0, 8'h03);
    base = pulse_cnt;
    step(10);
    bus_write(4'd0, 8'h00);
    bus_read(4'd0, rd);
    chk("R6 cfg locked", rd, 3);
    step(LEN_BS - 12);
    chk("R6 no early pulse", pulse_cnt - base, 0);
    step(1);
    chk("R6 late write did not clear", int'(rst_req_o), 1);

    // R7 first write clears a running count
    do_reset();
    step(50);
    bus_write(4'd0, 8'h03);
    base = pulse_cnt;
    step(LEN_BS - 1);
    chk("R7 no early pulse", pulse_cnt - base, 0);
    step(1);
    chk("R7 count restarted by config write", int'(rst_req_o), 1);

    // R5 service mid-count
    do_reset();
    bus_write(4'd0, 8'h03);
    base = pulse_cnt;
    step(20);
    bus_write(4'd1, 8'h00);
    step(LEN_BS - 1);
    chk("R5 service delayed pulse", pulse_cnt - base, 0);
    step(1);
    chk("R5 pulse one period after service", int'(rst_req_o), 1);

    // R10 service on the expiry edge
    do_reset();
    bus_write(4'd0, 8'h03);
    base = pulse_cnt;
    step(LEN_BS - 1);
    bus_write(4'd1, 8'hFF);
    chk("R10 service beats timeout", int'(rst_req_o), 0);
    step(LEN_BS - 1);
    chk("R10 no pulse after collision", pulse_cnt - base, 0);
    step(1);
    chk("R10 next pulse full period later", int'(rst_req_o), 1);

    // R11 long high level counts once
    do_reset();
    bus_write(4'd0, 8'h01);
    base = pulse_cnt;
    tick(40);
    for (int t = 0; t < LEN_SS - 2; t++) tick(3);
    chk("R11 held level counted once", pulse_cnt - base, 0);
    tick(3);
    chk("R11 pulse after edge count", pulse_cnt - base, 1);

    done = 1;
    finish_run();
  end
endmodule